// File: doc/BRIEF.md
# Typed Interrupt Source Bank

This block holds the per-source state of an interrupt controller. Each slot has a control word (vector, priority, mask, trigger sense, polarity and a read-only activity flag), a destination mask with one bit per CPU, and a pending flag. Every slot belongs to one of three kinds, fixed by its index at elaboration time. General slots take their trigger mode from their sense bit. Internal slots are always level-triggered. Timer/inter-processor slots are always edge-triggered and have no sense or polarity control.

Software writes a control word or a destination mask through one write port and reads either one back through a registered read port. Each slot has its own interrupt input line. Each CPU has its own acknowledge strobe, which carries the index of a source. During an acknowledge the block returns that source's vector in the same cycle. On the following edge it updates the pending flag, the activity flag and, for inter-processor slots, the destination mask. An inter-processor slot that is acknowledged by some of its target CPUs fires again for the CPUs that have not yet taken it. Arbitration and delivery to the CPUs are handled outside this block.

Top module: `irq_src_bank`

## Requirements
- R1: With the default parameters, slots 0..15 are general, slots 16..23 are internal (level) and slots 24..31 are timer/inter-processor (edge). Slots 28..31 are the inter-processor ones. `src_level` reports the current trigger mode of each slot (1 = level).
- R2: The control word has these fields: vector in bits [7:0], priority in [19:16], sense in [22] (1 = level), polarity in [23], activity in [30] and mask in [31] (1 = masked). A write changes only the mask, priority, sense, polarity and vector fields. Writing bit 30 has no effect, and every other bit reads zero.
- R3: After a control write to an internal slot, its sense bit reads 0. The slot stays level-triggered.
- R4: After a control write to a timer/inter-processor slot, its sense and polarity bits both read 0. The slot stays edge-triggered: a line held high does not re-raise it after it has been acknowledged.
- R5: After reset, every control word reads CTRL_RST (default 0x8000_0000) with activity clear, and every destination mask reads DEST_RST (default 1). Internal slots additionally read their polarity bit as 1. No slot is pending.
- R6: In a level-triggered slot, the pending flag equals the input line as sampled at the previous clock edge.
- R7: In an edge-triggered slot, a rising input sets the pending flag, and the flag stays set until the slot is acknowledged. An acknowledge clears both pending and activity. An acknowledge of a level-triggered slot leaves both unchanged.
- R8: When a CPU acknowledges an inter-processor slot, that CPU's bit is cleared from the slot's destination mask. If any destination bit remains set, the slot is pending again on the next cycle; otherwise it is no longer pending.
- R9: `ack_vec` for each CPU carries the vector field of the slot that CPU is acknowledging, in the same cycle as the strobe.
- R10: The activity bit reads 1 exactly when the slot was pending and unmasked at the last clock edge. A mask change therefore shows in the activity bit one cycle after the write. `rd_data` shows the addressed register one cycle after `rd_idx` and `rd_dest` are presented.
- R11: A general slot is level-triggered while its sense bit is 1 and edge-triggered while it is 0. The mode follows every control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_dest | input | 1 | 1 selects the destination mask, 0 the control word |
| wr_idx | input | IDX_W | Slot written |
| wr_data | input | 32 | Write data |
| rd_dest | input | 1 | 1 reads the destination mask, 0 the control word |
| rd_idx | input | IDX_W | Slot read |
| rd_data | output | 32 | Registered read data |
| irq_in | input | NUM_SRC | One interrupt line per slot |
| ack_req | input | NUM_CPU | Per-CPU acknowledge strobe |
| ack_idx | input | NUM_CPU*IDX_W | Per-CPU acknowledged slot index |
| ack_vec | output | NUM_CPU*VEC_W | Per-CPU vector of the acknowledged slot (same cycle) |
| src_pending | output | NUM_SRC | Pending flag of each slot |
| src_level | output | NUM_SRC | Current trigger mode of each slot (1 = level) |

## Verification
Pending, activity, control and destination state all change on the first clock edge after a line change, write or acknowledge. `rd_data` needs one more edge after the read address is set. `ack_vec` is valid combinationally while the strobe is held. The bench drives every input on the falling edge. It samples `ack_vec` shortly after driving the strobe, and it samples registered results on the next falling edge, so each check lands exactly one edge after its cause. Random control and destination writes are compared against a bench function that applies the write mask and the per-kind forcing.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  typedef enum logic [1:0] {
    SRC_GENERAL   = 2'd0,
    SRC_INTERNAL  = 2'd1,
    SRC_TIMER_IPI = 2'd2
  } src_kind_e;

  // control word field positions
  localparam int VEC_LSB  = 0;
  localparam int PRIO_LSB = 16;
  localparam int PRIO_W   = 4;
  localparam int SENSE_B  = 22;
  localparam int POL_B    = 23;
  localparam int ACT_B    = 30;
  localparam int MASK_B   = 31;

  function automatic src_kind_e kind_of(input int idx, input int ext_end, input int int_end);
    if (idx < ext_end)      return SRC_GENERAL;
    else if (idx < int_end) return SRC_INTERNAL;
    else                    return SRC_TIMER_IPI;
  endfunction

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_bank_pkg::*;
#(
  parameter src_kind_e   KIND     = SRC_GENERAL,
  parameter bit          IS_IPI   = 1'b0,
  parameter int          NUM_CPU  = 4,
  parameter int          VEC_W    = 8,
  parameter logic [31:0] CTRL_RST = 32'h8000_0000,
  parameter logic [31:0] DEST_RST = 32'h0000_0001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_we,
  input  logic               dest_we,
  input  logic [31:0]        wdata,
  input  logic               line,
  input  logic [NUM_CPU-1:0] ack_hit,
  output logic [31:0]        ctrl_o,
  output logic [NUM_CPU-1:0] dest_o,
  output logic               pending_o,
  output logic               level_o
);

  localparam logic [31:0] ACT_M   = 32'd1 << ACT_B;
  localparam logic [31:0] SENSE_M = 32'd1 << SENSE_B;
  localparam logic [31:0] POL_M   = 32'd1 << POL_B;
  localparam logic [31:0] WMASK   = (32'd1 << MASK_B) | SENSE_M | POL_M
                                  | (((32'd1 << PRIO_W) - 32'd1) << PRIO_LSB)
                                  | (((32'd1 << VEC_W) - 32'd1) << VEC_LSB);
  localparam logic [31:0] RST_EFF = ((KIND == SRC_INTERNAL) ? (CTRL_RST | POL_M) : CTRL_RST) & ~ACT_M;

  logic [31:0]        ctrl_q, ctrl_w, ctrl_base, ctrl_n;
  logic [NUM_CPU-1:0] dest_q, dest_base, dest_n;
  logic               pend_q, line_q, pend_n, act_n;
  logic               ack_any, refire, rise;

  always_comb begin
    unique case (KIND)
      SRC_GENERAL:  level_o = ctrl_q[SENSE_B];
      SRC_INTERNAL: level_o = 1'b1;
      default:      level_o = 1'b0;
    endcase
  end

  always_comb begin
    ctrl_w = (ctrl_q & ACT_M) | (wdata & WMASK);
    if (KIND == SRC_INTERNAL)  ctrl_w = ctrl_w & ~SENSE_M;
    if (KIND == SRC_TIMER_IPI) ctrl_w = ctrl_w & ~(SENSE_M | POL_M);
  end

  always_comb begin
    ctrl_base = ctrl_we ? ctrl_w : ctrl_q;
    dest_base = dest_we ? wdata[NUM_CPU-1:0] : dest_q;
    ack_any   = |ack_hit;
    dest_n    = IS_IPI ? (dest_base & ~ack_hit) : dest_base;
    refire    = IS_IPI && ack_any && (|dest_n) && !level_o;
    rise      = line && !line_q;
    pend_n    = level_o ? line : (refire || rise || (pend_q && !ack_any));
    act_n     = pend_n && !ctrl_base[MASK_B];
    ctrl_n    = ctrl_base;
    ctrl_n[ACT_B] = act_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= RST_EFF;
      dest_q <= DEST_RST[NUM_CPU-1:0];
      pend_q <= 1'b0;
      line_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      dest_q <= dest_n;
      pend_q <= pend_n;
      line_q <= line;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign dest_o    = dest_q;
  assign pending_o = pend_q;

  // level slots: pending tracks the line one edge later
  p_level_follow_r6: assert property (@(posedge clk) disable iff (rst)
    level_o |=> (pending_o == $past(line)));

  generate
    if (KIND == SRC_INTERNAL) begin : g_int_chk
      p_int_sense_clr_r3: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> !ctrl_o[SENSE_B]);
    end
    if (KIND == SRC_TIMER_IPI) begin : g_tmr_chk
      p_tmr_bits_clr_r4: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> (!ctrl_o[SENSE_B] && !ctrl_o[POL_B]));
    end
    if (!IS_IPI) begin : g_edge_chk
      p_edge_ack_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_any && !level_o && !(line && !line_q)) |=> (!pending_o && !ctrl_o[ACT_B]));
    end else begin : g_ipi_chk
      p_ipi_dest_clr_r8: assert property (@(posedge clk) disable iff (rst)
        (ack_any && !dest_we) |=> ((dest_o & $past(ack_hit)) == '0));
    end
  endgenerate

endmodule

// File: rtl/irq_ack_route.sv
module irq_ack_route #(
  parameter int NUM_SRC = 32,
  parameter int NUM_CPU = 4,
  parameter int VEC_W   = 8,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_CPU-1:0]         ack_req,
  input  logic [NUM_CPU*IDX_W-1:0]   ack_idx,
  input  logic [NUM_SRC*VEC_W-1:0]   vec_all,
  output logic [NUM_SRC*NUM_CPU-1:0] hit,
  output logic [NUM_CPU*VEC_W-1:0]   ack_vec
);

  generate
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic [IDX_W-1:0] sel;
      assign sel = ack_idx[c*IDX_W +: IDX_W];
      assign ack_vec[c*VEC_W +: VEC_W] =
        (32'(sel) < NUM_SRC) ? vec_all[32'(sel)*VEC_W +: VEC_W] : '0;
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign hit[s*NUM_CPU + c] = ack_req[c] && (sel == IDX_W'(s));
      end
    end
  endgenerate

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_bank_pkg::*;
#(
  parameter int          NUM_SRC  = 32,
  parameter int          EXT_END  = 16,
  parameter int          INT_END  = 24,
  parameter int          IPI_BASE = 28,
  parameter int          NUM_CPU  = 4,
  parameter int          VEC_W    = 8,
  parameter logic [31:0] CTRL_RST = 32'h8000_0000,
  parameter logic [31:0] DEST_RST = 32'h0000_0001,
  localparam int         IDX_W    = $clog2(NUM_SRC)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       wr_dest,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [31:0]                wr_data,
  input  logic                       rd_dest,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [31:0]                rd_data,
  input  logic [NUM_SRC-1:0]         irq_in,
  input  logic [NUM_CPU-1:0]         ack_req,
  input  logic [NUM_CPU*IDX_W-1:0]   ack_idx,
  output logic [NUM_CPU*VEC_W-1:0]   ack_vec,
  output logic [NUM_SRC-1:0]         src_pending,
  output logic [NUM_SRC-1:0]         src_level
);

  logic [31:0]                ctrl_all [NUM_SRC];
  logic [NUM_CPU-1:0]         dest_all [NUM_SRC];
  logic [NUM_SRC*VEC_W-1:0]   vec_all;
  logic [NUM_SRC*NUM_CPU-1:0] hit;

  irq_ack_route #(
    .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .VEC_W(VEC_W), .IDX_W(IDX_W)
  ) u_route (
    .ack_req (ack_req),
    .ack_idx (ack_idx),
    .vec_all (vec_all),
    .hit     (hit),
    .ack_vec (ack_vec)
  );

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
      localparam src_kind_e K = kind_of(i, EXT_END, INT_END);
      logic hit_we;
      assign hit_we = wr_en && (wr_idx == IDX_W'(i));

      irq_src_slot #(
        .KIND(K), .IS_IPI(i >= IPI_BASE), .NUM_CPU(NUM_CPU), .VEC_W(VEC_W),
        .CTRL_RST(CTRL_RST), .DEST_RST(DEST_RST)
      ) u_slot (
        .clk       (clk),
        .rst       (rst),
        .ctrl_we   (hit_we && !wr_dest),
        .dest_we   (hit_we && wr_dest),
        .wdata     (wr_data),
        .line      (irq_in[i]),
        .ack_hit   (hit[i*NUM_CPU +: NUM_CPU]),
        .ctrl_o    (ctrl_all[i]),
        .dest_o    (dest_all[i]),
        .pending_o (src_pending[i]),
        .level_o   (src_level[i])
      );

      assign vec_all[i*VEC_W +: VEC_W] = ctrl_all[i][VEC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (32'(rd_idx) >= NUM_SRC) begin
      rd_data <= '0;
    end else if (rd_dest) begin
      rd_data <= {{(32-NUM_CPU){1'b0}}, dest_all[rd_idx]};
    end else begin
      rd_data <= ctrl_all[rd_idx];
    end
  end

endmodule

// File: tb/irq_src_bank_tb.sv
module irq_src_bank_tb;

  localparam int NS = 32;
  localparam int NC = 4;
  localparam int IW = 5;
  localparam int VW = 8;

  logic            clk = 0;
  logic            rst = 1;
  logic            wr_en = 0, wr_dest = 0, rd_dest = 0;
  logic [IW-1:0]   wr_idx = '0, rd_idx = '0;
  logic [31:0]     wr_data = '0;
  logic [31:0]     rd_data;
  logic [NS-1:0]   irq_in = '0;
  logic [NC-1:0]   ack_req = '0;
  logic [NC*IW-1:0] ack_idx = '0;
  logic [NC*VW-1:0] ack_vec;
  logic [NS-1:0]   src_pending, src_level;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  irq_src_bank u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_dest(wr_dest), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_dest(rd_dest), .rd_idx(rd_idx), .rd_data(rd_data),
    .irq_in(irq_in), .ack_req(ack_req), .ack_idx(ack_idx), .ack_vec(ack_vec),
    .src_pending(src_pending), .src_level(src_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ctrl(input int idx, input logic [31:0] w);
    logic [31:0] r;
    r = w & 32'h80CF_00FF;
    if (idx >= 16 && idx < 24) r[22] = 1'b0;
    if (idx >= 24) r[23:22] = 2'b00;
    return r;
  endfunction

  task automatic wr(input bit dest, input int idx, input logic [31:0] d);
    wr_en = 1; wr_dest = dest; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input bit dest, input int idx, output logic [31:0] o);
    rd_dest = dest; rd_idx = IW'(idx);
    @(negedge clk);
    o = rd_data;
  endtask

  task automatic ack(input logic [NC-1:0] m, input int idx, input logic [7:0] expv);
    for (int c = 0; c < NC; c++) begin
      ack_req[c] = m[c];
      ack_idx[c*IW +: IW] = IW'(idx);
    end
    #1;
    for (int c = 0; c < NC; c++)
      if (m[c]) chk("R9 ack_vec", 32'(ack_vec[c*VW +: VW]), 32'(expv));
    @(negedge clk);
    ack_req = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;

    // reset state
    rd(0, 0, v);  chk("R5 general reset ctrl", v, 32'h8000_0000);
    rd(0, 16, v); chk("R5 internal reset ctrl", v, 32'h8080_0000);
    rd(0, 30, v); chk("R5 timer reset ctrl", v, 32'h8000_0000);
    rd(1, 7, v);  chk("R5 reset dest", v, 32'h1);
    chk("R5 nothing pending", src_pending, 32'h0);
    chk("R1 trigger layout", src_level, 32'h00FF_0000);

    // random register writes, all lines idle
    for (int i = 0; i < 60; i++) begin
      int idx;
      logic [31:0] d;
      bit dsel;
      idx = int'($urandom_range(NS-1, 0));
      d = $urandom;
      dsel = ($urandom_range(3, 0) == 0);
      wr(dsel, idx, d);
      rd(dsel, idx, v);
      if (dsel) chk("R8 dest write", v, {28'b0, d[3:0]});
      else      chk("R2 ctrl write mask", v, exp_ctrl(idx, d));
    end

    // internal slot: level behaviour
    wr(0, 18, 32'h0000_0012);
    irq_in[18] = 1; @(negedge clk);
    chk("R6 level pending set", 32'(src_pending[18]), 32'h1);
    rd(0, 18, v); chk("R10 activity on", v, 32'h4000_0012);
    ack(4'b0010, 18, 8'h12);
    chk("R7 level ack keeps pending", 32'(src_pending[18]), 32'h1);
    rd(0, 18, v); chk("R7 level ack keeps activity", v, 32'h4000_0012);
    irq_in[18] = 0; @(negedge clk);
    chk("R6 level pending drop", 32'(src_pending[18]), 32'h0);
    wr(0, 18, 32'h0040_0012);
    rd(0, 18, v); chk("R3 internal sense forced", v, 32'h0000_0012);
    chk("R3 internal stays level", 32'(src_level[18]), 32'h1);

    // general slot switched between modes
    chk("R11 general edge at reset", 32'(src_level[3]), 32'h0);
    wr(0, 3, 32'h0040_0033);
    chk("R11 general level by sense", 32'(src_level[3]), 32'h1);
    irq_in[3] = 1; @(negedge clk);
    chk("R11 level pending", 32'(src_pending[3]), 32'h1);
    irq_in[3] = 0; @(negedge clk);
    chk("R11 level pending drops", 32'(src_pending[3]), 32'h0);
    wr(0, 3, 32'h4000_0033);
    chk("R11 general back to edge", 32'(src_level[3]), 32'h0);
    rd(0, 3, v); chk("R2 activity not writable", v, 32'h0000_0033);
    irq_in[3] = 1; @(negedge clk);
    chk("R7 edge rise sets", 32'(src_pending[3]), 32'h1);
    irq_in[3] = 0; @(negedge clk); @(negedge clk);
    chk("R7 edge held", 32'(src_pending[3]), 32'h1);
    rd(0, 3, v); chk("R10 edge activity", v, 32'h4000_0033);
    ack(4'b0001, 3, 8'h33);
    chk("R7 edge ack clears", 32'(src_pending[3]), 32'h0);
    rd(0, 3, v); chk("R7 edge ack clears activity", v, 32'h0000_0033);

    // mask vs activity
    wr(0, 5, 32'h8000_0005);
    irq_in[5] = 1; @(negedge clk); irq_in[5] = 0;
    chk("R7 masked edge pending", 32'(src_pending[5]), 32'h1);
    rd(0, 5, v); chk("R10 masked no activity", v, 32'h8000_0005);
    wr(0, 5, 32'h0000_0005);
    rd(0, 5, v); chk("R10 unmask shows activity", v, 32'h4000_0005);
    ack(4'b1000, 5, 8'h05);

    // timer slot
    wr(0, 25, 32'h00C0_0025);
    rd(0, 25, v); chk("R4 timer sense/pol forced", v, 32'h0000_0025);
    chk("R4 timer edge", 32'(src_level[25]), 32'h0);
    irq_in[25] = 1; @(negedge clk);
    chk("R4 timer pending", 32'(src_pending[25]), 32'h1);
    ack(4'b0100, 25, 8'h25);
    chk("R4 held line no re-raise", 32'(src_pending[25]), 32'h0);
    @(negedge clk);
    chk("R4 still clear", 32'(src_pending[25]), 32'h0);
    irq_in[25] = 0;

    // inter-processor slot
    wr(0, 29, 32'h0000_0029);
    wr(1, 29, 32'h0000_0007);
    irq_in[29] = 1; @(negedge clk); irq_in[29] = 0;
    chk("R8 ipi pending", 32'(src_pending[29]), 32'h1);
    ack(4'b0001, 29, 8'h29);
    chk("R8 ipi refires", 32'(src_pending[29]), 32'h1);
    rd(1, 29, v); chk("R8 dest bit cleared", v, 32'h6);
    ack(4'b0110, 29, 8'h29);
    chk("R8 ipi done", 32'(src_pending[29]), 32'h0);
    rd(1, 29, v); chk("R8 dest empty", v, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule